// File: doc/BRIEF.md
# Converter Host Bus Interface

This block is the processor-facing side of a parallel-output analog-to-digital converter. It turns active-low chip select, write and read strobes, a mode strap, a bus-width select and a byte select into conversion start requests. It produces a conversion status line, a hold timing output, the latched 11-bit result (ten code bits and an over-range bit) and per-pin output enables for the tri-state pads. The converter core is outside the block. It receives a start pulse and returns a result with a valid strobe three clocks later.

There are three access styles. In on-demand mode the host starts each conversion with a write strobe and can wait on the status line. In free-running mode conversions run back to back after the first write, and an 8-bit host must read the high byte before the low byte. In streaming mode the strobes are tied low and results flow out with no host handshake.

Top module: `adc_host_if`

## Requirements
- R1: While rst_ni is low, hold_no is 1, start_o is 0 and data_o is all zeros. With cs_ni and rd_ni both high, data_oe_o and busy_oe_o are 0.
- R2: start_o stays 0 for the first INIT_CYC rising edges after reset is released, in every mode.
- R3: On-demand mode (mode_i=1 and not streaming) starts a conversion only when cs_ni is low and wr_ni has fallen. start_o is high in the cycle after the SYNC_STAGES-th consecutive edge that samples wr_ni low. A falling edge that reaches that point while a conversion is in flight is ignored.
- R4: In on-demand mode, holding both cs_ni and wr_ni low restarts a conversion in the same cycle the previous result returns.
- R5: In on-demand mode, busy_o is 0 from the edge that starts a conversion until the edge that takes its result, and 1 otherwise. In the other two modes busy_o is 0.
- R6: busy_oe_o is 1 exactly when cs_ni or rd_ni is low.
- R7: data_oe_o is all zeros unless cs_ni and rd_ni are both low. Then, with wide_i=1, all 11 bits are enabled. With wide_i=0, hi_sel_i=1 enables bits 10:8 and hi_sel_i=0 enables bits 7:0. Bit 10 of data_o is over-range and bits 9:0 are the code.
- R8: hold_no is low for HOLD_CYC cycles starting at each edge that takes start_o.
- R9: Free-running mode (mode_i=0) makes its first start once the synchronised wr_ni is low, regardless of cs_ni. After that it restarts every time a result returns, whatever the strobes do.
- R10: Streaming mode applies when mode_i=1 and cs_ni, rd_ni and the synchronised wr_ni are all low. It runs free like R9, and data bytes may be read in any order.
- R11: The output latch loads res_data_i at an edge where res_valid_i is 1 and holds otherwise. An on-demand read made while busy_o is 0 therefore shows the previous result.
- R12: In free-running mode, an edge that samples a high-byte read (cs_ni=0, rd_ni=0, wide_i=0, hi_sel_i=1) sets a lock. An edge that samples a low-byte read clears it. Results returning while the lock is set are discarded. No other mode locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Mode strap: 1 on-demand or streaming, 0 free-running |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low |
| wide_i | input | 1 | 1 drives all 11 bits, 0 selects byte access |
| hi_sel_i | input | 1 | Byte select: 1 high byte, 0 low byte |
| start_o | output | 1 | Start request to the converter core |
| res_valid_i | input | 1 | Result strobe from the core |
| res_data_i | input | RES_W+1 | Core result {over-range, code} |
| hold_no | output | 1 | Hold timing output, low while sampling |
| busy_o | output | 1 | Conversion status, 1 when complete |
| busy_oe_o | output | 1 | Output enable for busy_o |
| data_o | output | RES_W+1 | Latched result {over-range, code} |
| data_oe_o | output | RES_W+1 | Per-bit output enables |

## Verification
Several properties are checked on every cycle. Hold goes low after every start, and a start never overlaps a conversion still in flight. The start line stays quiet during initialisation. Free-running mode never reports busy. An idle bus enables nothing, the enable pattern always takes one of the four legal shapes, and the latch moves only after a returned result. Other behaviours depend on ordering and history, and only the scenario-driven reference model can show them: the write-synchroniser latency, an ignored second write, back-to-back restart, the discarded result under the byte lock, loss of a result after a low-first read, and streaming start-up.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef enum logic [1:0] {
    MODE_DEMAND = 2'd0,
    MODE_FREE   = 2'd1,
    MODE_STREAM = 2'd2
  } acc_mode_e;
endpackage

// File: rtl/adc_wr_sync.sv
module adc_wr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ni,
  output logic wr_lo_o,
  output logic wr_fall_o
);
  logic [STAGES-1:0] ff_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[0] <= 1'b1;
        else         ff_q[0] <= wr_ni;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[i] <= 1'b1;
        else         ff_q[i] <= ff_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= ff_q[STAGES-1];

  assign wr_lo_o   = ~ff_q[STAGES-1];
  assign wr_fall_o = prev_q & ~ff_q[STAGES-1];
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_host_pkg::*;
#(
  parameter int HOLD_CYC = 1,
  parameter int INIT_CYC = 6
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  acc_mode_e mode_i,
  input  logic      cs_ni,
  input  logic      wr_lo_i,
  input  logic      wr_fall_i,
  input  logic      res_valid_i,
  output logic      start_o,
  output logic      active_o,
  output logic      hold_no
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int IW = $clog2(INIT_CYC + 1);

  logic [IW-1:0] init_q;
  logic [HW-1:0] hold_q;
  logic          active_q, run_q, init_done, cont;

  assign init_done = (init_q == IW'(INIT_CYC));
  assign cont      = (mode_i != MODE_DEMAND);

  always_comb begin
    start_o = 1'b0;
    if (init_done) begin
      if (cont) start_o = run_q ? (~active_q | res_valid_i) : (wr_lo_i & ~active_q);
      else      start_o = ~cs_ni & ((wr_fall_i & ~active_q) | (wr_lo_i & res_valid_i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q   <= '0;
      hold_q   <= '0;
      active_q <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      if (!init_done) init_q <= init_q + 1'b1;
      if (start_o) begin
        active_q <= 1'b1;
        hold_q   <= HW'(HOLD_CYC);
        if (cont) run_q <= 1'b1;
      end else begin
        if (res_valid_i) active_q <= 1'b0;
        if (hold_q != '0) hold_q <= hold_q - 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign hold_no  = (hold_q == '0);
endmodule

// File: rtl/adc_out_latch.sv
module adc_out_latch #(
  parameter int BUS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_en_i,
  input  logic             hi_rd_i,
  input  logic             lo_rd_i,
  input  logic             res_valid_i,
  input  logic [BUS_W-1:0] res_data_i,
  output logic [BUS_W-1:0] data_o
);
  logic [BUS_W-1:0] data_q;
  logic             lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      lock_q <= 1'b0;
    end else begin
      if (res_valid_i && !(lock_en_i && lock_q)) data_q <= res_data_i;
      if (lock_en_i && hi_rd_i)      lock_q <= 1'b1;
      else if (lock_en_i && lo_rd_i) lock_q <= 1'b0;
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/adc_bus_drive.sv
module adc_bus_drive #(
  parameter int BUS_W = 11,
  parameter int LO_W  = 8
) (
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             wide_i,
  input  logic             hi_sel_i,
  input  logic             demand_i,
  input  logic             active_i,
  output logic             busy_o,
  output logic             busy_oe_o,
  output logic [BUS_W-1:0] data_oe_o
);
  localparam logic [BUS_W-1:0] LO_MASK = {{(BUS_W-LO_W){1'b0}}, {LO_W{1'b1}}};
  localparam logic [BUS_W-1:0] HI_MASK = ~LO_MASK;

  logic rd_sel;
  assign rd_sel = ~cs_ni & ~rd_ni;

  always_comb begin
    if (!rd_sel)       data_oe_o = '0;
    else if (wide_i)   data_oe_o = '1;
    else if (hi_sel_i) data_oe_o = HI_MASK;
    else               data_oe_o = LO_MASK;
  end

  assign busy_oe_o = ~cs_ni | ~rd_ni;
  assign busy_o    = demand_i & ~active_i;
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if
  import adc_host_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int LO_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 1,
  parameter int INIT_CYC    = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mode_i,
  input  logic           cs_ni,
  input  logic           wr_ni,
  input  logic           rd_ni,
  input  logic           wide_i,
  input  logic           hi_sel_i,
  output logic           start_o,
  input  logic           res_valid_i,
  input  logic [RES_W:0] res_data_i,
  output logic           hold_no,
  output logic           busy_o,
  output logic           busy_oe_o,
  output logic [RES_W:0] data_o,
  output logic [RES_W:0] data_oe_o
);
  localparam int BUS_W = RES_W + 1;

  logic      wr_lo, wr_fall, conv_act, byte_rd;
  acc_mode_e mode;

  always_comb begin
    if (!mode_i)                          mode = MODE_FREE;
    else if (!cs_ni && !rd_ni && wr_lo)   mode = MODE_STREAM;
    else                                  mode = MODE_DEMAND;
  end

  assign byte_rd = ~cs_ni & ~rd_ni & ~wide_i;

  adc_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .wr_ni,
    .wr_lo_o(wr_lo), .wr_fall_o(wr_fall)
  );

  adc_conv_seq #(.HOLD_CYC(HOLD_CYC), .INIT_CYC(INIT_CYC)) u_seq (
    .clk_i, .rst_ni, .mode_i(mode), .cs_ni,
    .wr_lo_i(wr_lo), .wr_fall_i(wr_fall), .res_valid_i,
    .start_o, .active_o(conv_act), .hold_no
  );

  adc_out_latch #(.BUS_W(BUS_W)) u_latch (
    .clk_i, .rst_ni,
    .lock_en_i(mode == MODE_FREE),
    .hi_rd_i(byte_rd & hi_sel_i), .lo_rd_i(byte_rd & ~hi_sel_i),
    .res_valid_i, .res_data_i, .data_o
  );

  adc_bus_drive #(.BUS_W(BUS_W), .LO_W(LO_W)) u_drive (
    .cs_ni, .rd_ni, .wide_i, .hi_sel_i,
    .demand_i(mode == MODE_DEMAND), .active_i(conv_act),
    .busy_o, .busy_oe_o, .data_oe_o
  );
endmodule

// File: rtl/adc_host_if_chk.sv
module adc_host_if_chk #(
  parameter int BUS_W    = 11,
  parameter int LO_W     = 8,
  parameter int INIT_CYC = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             cs_ni,
  input logic             rd_ni,
  input logic             start_o,
  input logic             hold_no,
  input logic             busy_o,
  input logic             busy_oe_o,
  input logic [BUS_W-1:0] data_oe_o,
  input logic             res_valid_i,
  input logic             conv_act,
  input logic [BUS_W-1:0] out_q
);
  int unsigned boot_cnt;
  int unsigned oe_ones;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                boot_cnt <= 0;
    else if (boot_cnt < 32'(INIT_CYC)) boot_cnt <= boot_cnt + 1;

  assign oe_ones = $countones(data_oe_o);

  // R8
  hold_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !hold_no) else $error("hold missing after start");
  // R3
  start_when_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (!conv_act || res_valid_i)) else $error("start overlaps conversion");
  // R2
  init_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_cnt < 32'(INIT_CYC)) |-> !start_o) else $error("start during init");
  // R5
  free_busy_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> !busy_o) else $error("busy high in free mode");
  // R6
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && rd_ni) |-> (data_oe_o == '0 && !busy_oe_o)) else $error("idle bus driven");
  // R7
  oe_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ones == 0 || oe_ones == BUS_W || oe_ones == LO_W || oe_ones == BUS_W - LO_W))
    else $error("bad enable shape");
  // R11
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(res_valid_i) |-> $stable(out_q)) else $error("latch moved without result");
endmodule

bind adc_host_if adc_host_if_chk #(.BUS_W(RES_W + 1), .LO_W(LO_W), .INIT_CYC(INIT_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .cs_ni(cs_ni), .rd_ni(rd_ni),
  .start_o(start_o), .hold_no(hold_no), .busy_o(busy_o), .busy_oe_o(busy_oe_o),
  .data_oe_o(data_oe_o), .res_valid_i(res_valid_i), .conv_act(conv_act), .out_q(data_o)
);

// File: tb/tb_adc_host_if.sv
module tb_adc_host_if;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 10;
  localparam int BW    = RES_W + 1;
  localparam int LO_W  = 8;
  localparam int SYNC  = 2;
  localparam int HOLD  = 1;
  localparam int INIT  = 6;
  localparam int WDOG  = 5000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b1, cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, wide = 1'b1, hi_sel = 1'b0;
  logic start_o, hold_no, busy_o, busy_oe_o;
  logic [BW-1:0] data_o, data_oe_o;
  logic          res_valid;
  logic [BW-1:0] res_data;
  logic [2:0]    stub_sr;
  int            res_idx;
  logic          start_cap = 1'b0;

  int nvec = 0, nmis = 0, ncyc = 0;
  bit vec_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_host_if #(.RES_W(RES_W), .LO_W(LO_W), .SYNC_STAGES(SYNC), .HOLD_CYC(HOLD), .INIT_CYC(INIT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cs_ni(cs_n), .wr_ni(wr_n), .rd_ni(rd_n),
    .wide_i(wide), .hi_sel_i(hi_sel), .start_o(start_o), .res_valid_i(res_valid),
    .res_data_i(res_data), .hold_no(hold_no), .busy_o(busy_o), .busy_oe_o(busy_oe_o),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );

  // core stub: result three clocks after the start edge
  assign res_valid = stub_sr[2];
  assign res_data  = BW'((res_idx * 173 + 91) % 2048);
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin stub_sr <= '0; res_idx <= 0; end
    else begin
      stub_sr <= {stub_sr[1:0], start_cap};
      if (stub_sr[2]) res_idx <= res_idx + 1;
    end

  // reference model
  bit       m_act, m_run, m_lock;
  int       m_hold, m_init;
  logic [BW-1:0] m_out;
  bit       wrq[$];

  function automatic int m_mode();  // 0 demand, 1 free, 2 stream
    if (!mode) return 1;
    if (!cs_n && !rd_n && !wrq[SYNC-1]) return 2;
    return 0;
  endfunction

  function automatic bit m_start();
    bit wl = !wrq[SYNC-1];
    bit fl = wrq[SYNC] && wl;
    if (m_init < INIT) return 0;
    if (m_mode() != 0) return m_run ? (!m_act || res_valid) : (wl && !m_act);
    return !cs_n && ((fl && !m_act) || (wl && res_valid));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_run = 0; m_lock = 0; m_hold = 0; m_init = 0; m_out = '0;
      wrq = {};
      repeat (SYNC + 1) wrq.push_back(1'b1);
    end else begin
      bit st;
      int md;
      st = m_start();
      md = m_mode();
      if (st) begin
        m_act = 1; m_hold = HOLD;
        if (md != 0) m_run = 1;
      end else begin
        if (res_valid) m_act = 0;
        if (m_hold > 0) m_hold--;
      end
      if (m_init < INIT) m_init++;
      if (res_valid && !(md == 1 && m_lock)) m_out = res_data;
      if (md == 1 && !cs_n && !rd_n && !wide) m_lock = hi_sel;
      wrq.push_front(wr_n);
      void'(wrq.pop_back());
    end
  end

  task automatic check(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    if (act !== exp) begin
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
      vec_bad = 1;
    end
  endtask

  always @(negedge clk) begin
    start_cap = start_o;
    ncyc++;
    if (ncyc > WDOG) begin
      $display("FAIL watchdog: got %0d cycles expected <= %0d", ncyc, WDOG);
      nmis++;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
    if (rst_n) begin
      int md;
      logic [BW-1:0] e_oe;
      md = m_mode();
      if (cs_n || rd_n) e_oe = '0;
      else if (wide)    e_oe = '1;
      else if (hi_sel)  e_oe = 11'h700;
      else              e_oe = 11'h0FF;
      vec_bad = 0;
      check(m_init < INIT ? "R2" : (md == 0 ? "R3/R4" : (md == 1 ? "R9" : "R10")),
            BW'(start_o), BW'(m_start()));
      check("R8", BW'(hold_no), BW'(m_hold == 0));
      check("R5", BW'(busy_o), BW'((md == 0) && !m_act));
      check("R6", BW'(busy_oe_o), BW'(!cs_n || !rd_n));
      check("R7", data_oe_o, e_oe);
      check(md == 1 ? "R12" : "R11", data_o, m_out);
      nvec++;
      if (vec_bad) nmis++;
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic directed(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    vec_bad = 0;
    check(tag, act, exp);
    nvec++;
    if (vec_bad) nmis++;
  endtask

  task automatic do_reset(logic m, logic c, logic w, logic r, logic wd);
    rst_n = 0; mode = m; cs_n = c; wr_n = w; rd_n = r; wide = wd; hi_sel = 0;
    cyc(2);
    rst_n = 1;
  endtask

  task automatic wr_pulse();
    wr_n = 0; cyc(1); wr_n = 1;
  endtask

  initial begin
    logic [BW-1:0] held;
    // R1 reset state
    #3;
    directed("R1", BW'(hold_no), BW'(1));
    directed("R1", BW'(start_o), BW'(0));
    directed("R1", data_o, '0);
    directed("R1", data_oe_o, '0);
    directed("R1", BW'(busy_oe_o), BW'(0));
    cyc(2);

    // on-demand, wide bus: single start, ignored second edge, read while busy
    do_reset(1, 1, 1, 1, 1);
    cyc(8);
    cs_n = 0;
    wr_n = 0; cyc(1); wr_n = 1; cyc(1);
    wr_n = 0; cyc(1); wr_n = 1;          // lands while active: ignored (R3)
    rd_n = 0; cyc(6);                    // old data during busy (R11)
    rd_n = 1; cs_n = 1; cyc(2);
    cs_n = 0; wr_pulse(); cs_n = 1; cyc(6); // cs high before sync: no start (R3)

    // on-demand continuous (R4)
    cs_n = 0; wr_n = 0; cyc(12);
    wr_n = 1; cyc(5); cs_n = 1; cyc(2);

    // on-demand byte reads, either order
    wide = 0; cs_n = 0; wr_pulse(); cyc(6);
    rd_n = 0; hi_sel = 0; cyc(2); hi_sel = 1; cyc(2); rd_n = 1;
    wr_pulse(); cyc(6);
    rd_n = 0; hi_sel = 1; cyc(2); hi_sel = 0; cyc(2); rd_n = 1; cs_n = 1; cyc(2);

    // free-running: wr high keeps it idle, then first start (R9)
    do_reset(0, 1, 1, 1, 0);
    cyc(10);
    directed("R9", BW'(start_o), BW'(0));
    wr_pulse(); cyc(9);
    // high byte locks, results discarded until low read (R12)
    cs_n = 0; rd_n = 0; hi_sel = 1; cyc(1); rd_n = 1;
    held = data_o;
    cyc(7);
    directed("R12", data_o, held);
    rd_n = 0; hi_sel = 0; cyc(1); rd_n = 1; cyc(6);
    // low byte first: later high read locks and loses results
    rd_n = 0; hi_sel = 0; cyc(1); hi_sel = 1; cyc(1); rd_n = 1; cyc(6);
    rd_n = 0; hi_sel = 0; cyc(1); rd_n = 1; cyc(4);
    wide = 1; rd_n = 0; cyc(4); rd_n = 1; cs_n = 1; cyc(3);

    // streaming (R10)
    do_reset(1, 0, 0, 0, 1);
    cyc(20);
    wide = 0; hi_sel = 0; cyc(3); hi_sel = 1; cyc(5); hi_sel = 0; cyc(4);
    wide = 1; cyc(6);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule